// File: doc/BRIEF.md
# Receive FIFO Trigger Level Controller

This block watches the fill level of a receive FIFO and compares it against an upper and a lower threshold. The upper threshold raises a receive-data interrupt request and asserts a flow-control hold. The lower threshold releases the hold, so the gap between the two thresholds gives hysteresis. The FIFO itself, interrupt prioritisation and the generation of pause or resume signalling on the line are handled elsewhere.

The thresholds come from one of four modes. Single-byte mode forces every level to 1. Two preset modes, for a 16-entry and a 128-entry FIFO, take their levels from a 2-bit code. A programmable mode takes both thresholds from two 8-bit inputs and ignores the code. Every input is sampled at the clock edge, and both outputs are registered.

Top module: `rx_trigger_ctrl`

## Requirements
- R1: A synchronous active-high reset clears `irq_req` and `flow_hold`. Both stay 0 while reset is held, whatever the other inputs are.
- R2: Mode 2'b01 (16-entry presets) maps `trig_code` 00/01/10/11 to upper levels 1/4/8/14. The lower level is 1 for every code.
- R3: Mode 2'b10 (128-entry presets) maps `trig_code` 00/01/10/11 to upper levels 16/32/112/120 and lower levels 1/16/32/112.
- R4: Mode 2'b00 (single-byte) uses an upper and a lower level of 1 for every `trig_code`.
- R5: Mode 2'b11 (programmable) takes the upper level from `prog_upper` and the lower level from `prog_lower`. `trig_code` has no effect in this mode.
- R6: In programmable mode, a `prog_upper` of 0 is treated as an upper level of 1.
- R7: In programmable mode, a `prog_lower` at or above the effective upper level is treated as the upper level minus 1.
- R8: `irq_req` is 1 one clock after an edge at which `irq_en` was 1 and `fifo_level` was at or above the upper level. Otherwise it is 0. The request is level-based and drops one clock after the level falls below the upper level or `irq_en` falls.
- R9: `flow_hold` becomes 1 one clock after an edge at which `fifo_level` is at or above the upper level. It does not depend on `irq_en`.
- R10: `flow_hold` becomes 0 one clock after an edge at which `fifo_level` is at or below the lower level and below the upper level. Between the two levels it keeps its previous value.
- R11: A change of mode, code or programmable threshold takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_level | input | 8 | Current receive FIFO fill level |
| irq_en | input | 1 | Enables the receive-data interrupt request |
| trig_code | input | 2 | Preset trigger level select |
| rx_mode | input | 2 | 00 single-byte, 01 16-entry presets, 10 128-entry presets, 11 programmable |
| prog_upper | input | 8 | Programmable upper threshold |
| prog_lower | input | 8 | Programmable lower threshold |
| irq_req | output | 1 | Receive-data interrupt request (registered) |
| flow_hold | output | 1 | Flow-control hold with hysteresis (registered) |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it, because the threshold selection is combinational and both outputs are single registers. The bench changes inputs on the falling edge and samples on the next falling edge, so each check sees the edge that consumed the stimulus and no other. Each threshold is found through the ports: the interrupt is probed at one below and at the upper level, and the hold release is probed at one above and at the lower level.

// File: rtl/rxt_pkg.sv
package rxt_pkg;

    localparam int TH_W = 8;

    typedef logic [TH_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        MODE_BYTE = 2'b00,
        MODE_D16  = 2'b01,
        MODE_D128 = 2'b10,
        MODE_PROG = 2'b11
    } rx_mode_e;

    typedef struct packed {
        lvl_t upper;
        lvl_t lower;
    } thresh_t;

    function automatic thresh_t preset_d16(input logic [1:0] code);
        thresh_t t;
        t.lower = lvl_t'(1);
        case (code)
            2'b00:   t.upper = lvl_t'(1);
            2'b01:   t.upper = lvl_t'(4);
            2'b10:   t.upper = lvl_t'(8);
            default: t.upper = lvl_t'(14);
        endcase
        return t;
    endfunction

    function automatic thresh_t preset_d128(input logic [1:0] code);
        thresh_t t;
        case (code)
            2'b00:   begin t.upper = lvl_t'(16);  t.lower = lvl_t'(1);   end
            2'b01:   begin t.upper = lvl_t'(32);  t.lower = lvl_t'(16);  end
            2'b10:   begin t.upper = lvl_t'(112); t.lower = lvl_t'(32);  end
            default: begin t.upper = lvl_t'(120); t.lower = lvl_t'(112); end
        endcase
        return t;
    endfunction

    function automatic thresh_t clamp_prog(input lvl_t up, input lvl_t lo);
        thresh_t t;
        t.upper = (up == '0) ? lvl_t'(1) : up;
        t.lower = (lo >= t.upper) ? t.upper - lvl_t'(1) : lo;
        return t;
    endfunction

endpackage

// File: rtl/rxt_thresh_sel.sv
module rxt_thresh_sel
    import rxt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  rx_mode_e         mode,
    input  logic [1:0]       code,
    input  lvl_t             prog_up,
    input  lvl_t             prog_lo,
    output thresh_t          th
);

    always_comb begin
        unique case (mode)
            MODE_BYTE: begin
                th.upper = lvl_t'(1);
                th.lower = lvl_t'(1);
            end
            MODE_D16:  th = preset_d16(code);
            MODE_D128: th = preset_d128(code);
            default:   th = clamp_prog(prog_up, prog_lo);
        endcase
    end

    // R6: no mode ever yields an upper level of zero
    assert_upper_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        th.upper != '0);

    // R7: programmable lower level always sits strictly below the upper level
    assert_prog_lower_below_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PROG) |-> (th.lower < th.upper));

endmodule

// File: rtl/rxt_flow_hyst.sv
module rxt_flow_hyst
    import rxt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  lvl_t    level,
    input  thresh_t th,
    output logic    hold
);

    logic at_upper, at_lower;

    assign at_upper = (level >= th.upper);
    assign at_lower = (level <= th.lower);

    always_ff @(posedge clk) begin
        if (rst)
            hold <= 1'b0;
        else if (at_upper)
            hold <= 1'b1;
        else if (at_lower)
            hold <= 1'b0;
    end

    // R9: hold only rises after the level reached the upper threshold
    assert_hold_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(hold) |-> $past(at_upper));

    // R10: hold only falls after the level dropped to the lower threshold
    assert_hold_fall_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> ($past(at_lower) && !$past(at_upper)));

endmodule

// File: rtl/rxt_irq_gen.sv
module rxt_irq_gen
    import rxt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  lvl_t    level,
    input  thresh_t th,
    output logic    irq
);

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= en && (level >= th.upper);
    end

    // R1: the first cycle after reset never carries a request
    assert_irq_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);

    // R8: a request implies the enable was set on the previous edge
    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(en));

    // R8: a request implies the level was at the upper threshold on the previous edge
    assert_irq_needs_level_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !$past(rst)) |-> ($past(level) >= $past(th.upper)));

endmodule

// File: rtl/rx_trigger_ctrl.sv
module rx_trigger_ctrl
    import rxt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [TH_W-1:0] fifo_level,
    input  logic            irq_en,
    input  logic [1:0]      trig_code,
    input  logic [1:0]      rx_mode,
    input  logic [TH_W-1:0] prog_upper,
    input  logic [TH_W-1:0] prog_lower,
    output logic            irq_req,
    output logic            flow_hold
);

    rx_mode_e mode_e;
    thresh_t  th;

    assign mode_e = rx_mode_e'(rx_mode);

    rxt_thresh_sel u_sel (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_e),
        .code    (trig_code),
        .prog_up (prog_upper),
        .prog_lo (prog_lower),
        .th      (th)
    );

    rxt_flow_hyst u_hyst (
        .clk   (clk),
        .rst   (rst),
        .level (fifo_level),
        .th    (th),
        .hold  (flow_hold)
    );

    rxt_irq_gen u_irq (
        .clk   (clk),
        .rst   (rst),
        .en    (irq_en),
        .level (fifo_level),
        .th    (th),
        .irq   (irq_req)
    );

    // R1: both outputs are clear on the cycle after reset
    assert_outputs_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_req && !flow_hold));

endmodule

// File: tb/rx_trigger_ctrl_bench.sv
module rx_trigger_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] fifo_level = '0;
    logic       irq_en = 1'b0;
    logic [1:0] trig_code = '0;
    logic [1:0] rx_mode = '0;
    logic [7:0] prog_upper = '0;
    logic [7:0] prog_lower = '0;
    logic       irq_req, flow_hold;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_trigger_ctrl u_rx_trigger_ctrl (
        .clk(clk), .rst(rst), .fifo_level(fifo_level), .irq_en(irq_en),
        .trig_code(trig_code), .rx_mode(rx_mode), .prog_upper(prog_upper),
        .prog_lower(prog_lower), .irq_req(irq_req), .flow_hold(flow_hold)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // drive level on a falling edge, let one rising edge consume it, sample on next falling edge
    task automatic step(input logic [7:0] lvl);
        fifo_level = lvl;
        @(negedge clk);
    endtask

    // discover both thresholds through the ports and compare with expectations
    task automatic probe(input string req, input logic [1:0] mode, input logic [1:0] code,
                         input logic [7:0] pu, input logic [7:0] pl,
                         input int exp_up, input int exp_lo);
        rx_mode = mode; trig_code = code; prog_upper = pu; prog_lower = pl; irq_en = 1'b1;
        step(8'd0);
        check({req, " hold clear at level 0"}, flow_hold, 1'b0);
        step(8'(exp_up - 1));
        check({req, " irq below upper"}, irq_req, 1'b0);
        step(8'(exp_up));
        check({req, " irq at upper"}, irq_req, 1'b1);
        check({req, " hold at upper"}, flow_hold, 1'b1);
        if (exp_lo + 1 < exp_up) begin
            step(8'(exp_lo + 1));
            check({req, " hold kept above lower R10"}, flow_hold, 1'b1);
            check({req, " irq dropped below upper R8"}, irq_req, 1'b0);
        end
        step(8'((exp_lo < exp_up) ? exp_lo : exp_lo - 1));
        check({req, " hold released at lower R10"}, flow_hold, 1'b0);
    endtask

    task automatic t_reset_r1();
        rst = 1'b1; irq_en = 1'b1; rx_mode = 2'b00; fifo_level = 8'd200;
        @(negedge clk); @(negedge clk);
        check("R1 irq in reset", irq_req, 1'b0);
        check("R1 hold in reset", flow_hold, 1'b0);
        fifo_level = 8'd0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 irq after reset", irq_req, 1'b0);
    endtask

    task automatic t_byte_r4();
        for (int c = 0; c < 4; c++) probe("R4 byte", 2'b00, 2'(c), 8'd0, 8'd0, 1, 1);
    endtask

    task automatic t_d16_r2();
        int ups[4] = '{1, 4, 8, 14};
        for (int c = 0; c < 4; c++) probe("R2 d16", 2'b01, 2'(c), 8'd0, 8'd0, ups[c], 1);
    endtask

    task automatic t_d128_r3();
        int ups[4] = '{16, 32, 112, 120};
        int los[4] = '{1, 16, 32, 112};
        for (int c = 0; c < 4; c++) probe("R3 d128", 2'b10, 2'(c), 8'd0, 8'd0, ups[c], los[c]);
    endtask

    task automatic t_prog_r5();
        for (int c = 0; c < 4; c++) probe("R5 prog", 2'b11, 2'(c), 8'd50, 8'd20, 50, 20);
        probe("R5 prog max", 2'b11, 2'b01, 8'd255, 8'd3, 255, 3);
    endtask

    task automatic t_clamp_r6_r7();
        probe("R6 zero upper", 2'b11, 2'b00, 8'd0, 8'd0, 1, 0);
        probe("R7 lower above upper", 2'b11, 2'b10, 8'd10, 8'd40, 10, 9);
        probe("R7 lower equal upper", 2'b11, 2'b11, 8'd10, 8'd10, 10, 9);
    endtask

    task automatic t_enable_r8_r9();
        rx_mode = 2'b01; trig_code = 2'b10; irq_en = 1'b0;
        step(8'd0);
        step(8'd9);
        check("R8 irq masked", irq_req, 1'b0);
        check("R9 hold ignores enable", flow_hold, 1'b1);
        irq_en = 1'b1;
        @(negedge clk);
        check("R8 irq after enable", irq_req, 1'b1);
        irq_en = 1'b0;
        @(negedge clk);
        check("R8 irq drops with enable", irq_req, 1'b0);
    endtask

    task automatic t_hyst_r10();
        rx_mode = 2'b10; trig_code = 2'b01; irq_en = 1'b1;
        step(8'd0);
        step(8'd20);
        check("R10 stays clear rising between levels", flow_hold, 1'b0);
        step(8'd32);
        check("R9 set at upper", flow_hold, 1'b1);
        step(8'd17);
        check("R10 kept falling between levels", flow_hold, 1'b1);
        step(8'd16);
        check("R10 clear at lower", flow_hold, 1'b0);
    endtask

    task automatic t_change_r11();
        rx_mode = 2'b10; trig_code = 2'b00; irq_en = 1'b1;
        step(8'd16);
        check("R11 irq with d128 code 00", irq_req, 1'b1);
        trig_code = 2'b01;
        @(negedge clk);
        check("R11 irq drops after code change", irq_req, 1'b0);
        rx_mode = 2'b11; prog_upper = 8'd16; prog_lower = 8'd2;
        @(negedge clk);
        check("R11 irq after mode change", irq_req, 1'b1);
        prog_upper = 8'd17;
        @(negedge clk);
        check("R11 irq drops after threshold change", irq_req, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset_r1();
        t_byte_r4();
        t_d16_r2();
        t_d128_r3();
        t_prog_r5();
        t_clamp_r6_r7();
        t_enable_r8_r9();
        t_hyst_r10();
        t_change_r11();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule